// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Wait States

This block turns a 24-bit bus address into a set of active-low device selects, one per channel. It has twelve channels. Each channel holds a base address, a block-size code, an access-length code and a direction mask. When the bus strobe is seen while no access is in progress, every channel whose window contains the address asserts its select. The select holds for the programmed number of clocks, and a one-clock acknowledge in the last of those clocks ends the bus cycle.

The decoder compares address bits 19 down to the block-size boundary. The top four address lines only mirror bit 19, so the decoder ignores them and 512 KB is the largest window. Configuration arrives through a single write port. A write issued while the decoder is idle takes effect at once. A write issued during an access is parked and applied at the clock edge that ends the access, so an access in progress never sees its configuration change.

Top module: `csel_bank`

## Requirements
- R1: Each channel is configured by one cycle of `cfg_we` with `cfg_idx` naming the channel. The fields are `cfg_base` (address bits 19:11), `cfg_size`, `cfg_len` and `cfg_dir`. After reset every channel has size code 0.
- R2: Size codes 1..7 give windows of 2K, 8K, 16K, 64K, 128K, 256K and 512K bytes. An address hits when its bits 19 down to log2(window) equal the same bits of the base. Base bits below the window boundary are ignored.
- R3: Address bits 23:20 never influence a hit.
- R4: A channel with size code 0, or with direction mask 0, never asserts its select. Direction bit 0 admits reads (`bus_rd`=1) and bit 1 admits writes (`bus_rd`=0).
- R5: The strobe is sampled high at a rising edge while idle, with at least one hit. From that edge the matching selects are low for L clocks, where L = 2 for length codes 0 and 1 and L = code+1 otherwise (2..16). The selects do not change during those L clocks.
- R6: `bus_ack` is high for exactly one clock, the last of the L. All selects are released at the following edge.
- R7: When several channels hit, all of their selects assert together. L is taken from the lowest-numbered channel that hits.
- R8: A strobe during an access is ignored. A strobe that hits no channel produces neither a select nor an acknowledge.
- R9: A write issued during an access leaves that access unchanged. The write is held and applied at the edge that ends the access. A later write in the same access replaces the held one. A write issued while idle applies at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Channel written |
| cfg_base | input | 9 | Base address bits 19:11 |
| cfg_size | input | 3 | Window size code (0 = off) |
| cfg_len | input | 4 | Access length code |
| cfg_dir | input | 2 | Direction mask: bit 0 read, bit 1 write |
| bus_addr | input | 24 | Bus address |
| bus_strb | input | 1 | Bus cycle start strobe |
| bus_rd | input | 1 | 1 = read, 0 = write |
| cs_n | output | 12 | Active-low per-channel selects |
| bus_ack | output | 1 | Cycle termination pulse |

## Verification
Every size code is tried with five addresses around a base whose low bits are deliberately misaligned. The addresses are the first and last byte of the window, the bytes just outside it on both sides, and an in-window address with the mirrored top bits set. These separate a wrong mask width, a base that is not masked, and a comparison that wrongly includes the upper bits. All sixteen length codes are run on one channel to pin down the length mapping and the acknowledge position. Overlapping windows with different lengths, direction masks, a repeated strobe, and one or two configuration writes inside an access cover priority, qualification, and deferral with replacement of the held write.

// File: rtl/csel_pkg.sv
package csel_pkg;

   localparam int SIZE_W = 3;
   localparam int LEN_W  = 4;
   localparam int DIR_W  = 2;

   typedef struct packed {
      logic [SIZE_W-1:0] size;
      logic [LEN_W-1:0]  len;
      logic [DIR_W-1:0]  dir;
   } ch_ctrl_t;

   // window size as a shift above the smallest window (2K)
   function automatic int unsigned blk_shift(input logic [SIZE_W-1:0] code);
      case (code)
         3'd1:    return 0;
         3'd2:    return 2;
         3'd3:    return 3;
         3'd4:    return 5;
         3'd5:    return 6;
         3'd6:    return 7;
         3'd7:    return 8;
         default: return 0;
      endcase
   endfunction

   // clocks an access lasts for a given length code
   function automatic logic [LEN_W:0] len_clocks(input logic [LEN_W-1:0] code);
      if (code < LEN_W'(2)) return (LEN_W+1)'(2);
      return {1'b0, code} + (LEN_W+1)'(1);
   endfunction

endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
   import csel_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int IDX_W  = 4,
   parameter int BASE_W = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [BASE_W-1:0]             wr_base,
   input  ch_ctrl_t                      wr_ctrl,
   input  logic                          busy,
   input  logic                          access_end,
   output logic [NUM_CH-1:0][BASE_W-1:0] base_q,
   output ch_ctrl_t [NUM_CH-1:0]         ctrl_q
);

   logic              pend_v;
   logic [IDX_W-1:0]  pend_idx;
   logic [BASE_W-1:0] pend_base;
   ch_ctrl_t          pend_ctrl;

   logic              apply;
   logic [IDX_W-1:0]  src_idx;
   logic [BASE_W-1:0] src_base;
   ch_ctrl_t          src_ctrl;

   // idle: write goes straight in; busy: only at the closing edge
   assign apply    = busy ? (access_end && (wr_en || pend_v)) : wr_en;
   assign src_idx  = wr_en ? wr_idx  : pend_idx;
   assign src_base = wr_en ? wr_base : pend_base;
   assign src_ctrl = wr_en ? wr_ctrl : pend_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_idx  <= '0;
         pend_base <= '0;
         pend_ctrl <= '0;
      end else if (busy && !access_end && wr_en) begin
         pend_v    <= 1'b1;
         pend_idx  <= wr_idx;
         pend_base <= wr_base;
         pend_ctrl <= wr_ctrl;
      end else if (access_end) begin
         pend_v    <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ctrl_q <= '0;
      end else if (apply) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (src_idx == IDX_W'(i)) begin
               base_q[i] <= src_base;
               ctrl_q[i] <= src_ctrl;
            end
         end
      end
   end

   // R9: configuration is frozen inside an access
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !access_end) |=> ($stable(base_q) && $stable(ctrl_q)));

   // R9: the held write is consumed when the access ends
   p_pend_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
      access_end |=> !pend_v);

endmodule

// File: rtl/csel_match.sv
module csel_match
   import csel_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int BASE_W = 9
) (
   input  logic [BASE_W-1:0]             addr_f,
   input  logic                          rd,
   input  logic [NUM_CH-1:0][BASE_W-1:0] base_q,
   input  ch_ctrl_t [NUM_CH-1:0]         ctrl_q,
   output logic [NUM_CH-1:0]             hit
);

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic [BASE_W-1:0] mask;
      logic              dir_ok;
      logic              armed;

      assign mask   = {BASE_W{1'b1}} << blk_shift(ctrl_q[gi].size);
      assign dir_ok = rd ? ctrl_q[gi].dir[0] : ctrl_q[gi].dir[1];
      assign armed  = (ctrl_q[gi].size != '0) && dir_ok;
      assign hit[gi] = armed && (((addr_f ^ base_q[gi]) & mask) == '0);
   end

endmodule

// File: rtl/csel_seq.sv
module csel_seq
   import csel_pkg::*;
#(
   parameter int NUM_CH = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  strb,
   input  logic [NUM_CH-1:0]     hit,
   input  ch_ctrl_t [NUM_CH-1:0] ctrl_q,
   output logic [NUM_CH-1:0]     sel_q,
   output logic                  busy,
   output logic                  ack
);

   logic [LEN_W-1:0] first_len;
   logic [LEN_W:0]   clocks;
   logic [LEN_W-1:0] cnt;
   logic             start;

   // lowest-numbered hit sets the length
   always_comb begin
      first_len = '0;
      for (int i = NUM_CH-1; i >= 0; i--) begin
         if (hit[i]) first_len = ctrl_q[i].len;
      end
   end

   assign clocks = len_clocks(first_len);
   assign start  = strb && !busy && (hit != '0);
   assign ack    = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         sel_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt   <= LEN_W'(clocks - (LEN_W+1)'(1));
         sel_q <= hit;
      end else if (busy) begin
         if (cnt == '0) begin
            busy  <= 1'b0;
            sel_q <= '0;
         end else begin
            cnt <= cnt - LEN_W'(1);
         end
      end
   end

   // R5: selects follow the hits captured at the strobe
   p_start_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !busy && (hit != '0)) |=> (busy && sel_q == $past(hit)));

   // R5: no acknowledge in the first clock (minimum length 2)
   p_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !ack);

   // R5: selects steady until acknowledge
   p_sel_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ack) |=> (busy && $stable(sel_q)));

   // R6: acknowledge is one clock, then everything releases
   p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!ack && !busy && sel_q == '0));

   // R8: strobe without a hit starts nothing
   p_no_hit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !busy && (hit == '0)) |=> !busy);

endmodule

// File: rtl/csel_bank.sv
module csel_bank
   import csel_pkg::*;
#(
   parameter int NUM_CH     = 12,
   parameter int ADDR_W     = 24,
   parameter int MIRROR_BIT = 19,
   parameter int MIN_LOG    = 11,
   localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int BASE_W    = MIRROR_BIT - MIN_LOG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [BASE_W-1:0] cfg_base,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [DIR_W-1:0]  cfg_dir,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_strb,
   input  logic              bus_rd,
   output logic [NUM_CH-1:0] cs_n,
   output logic              bus_ack
);

   if (MIRROR_BIT >= ADDR_W) begin : g_bad_mirror
      $error("MIRROR_BIT must lie inside the address");
   end
   if (BASE_W < 9) begin : g_bad_span
      $error("compare span must cover 2K to 512K windows");
   end
   if (MIN_LOG < 1) begin : g_bad_min
      $error("MIN_LOG must be positive");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0][BASE_W-1:0] base_q;
   ch_ctrl_t [NUM_CH-1:0]         ctrl_q;
   ch_ctrl_t                      wr_ctrl;
   logic [NUM_CH-1:0]             hit;
   logic [NUM_CH-1:0]             sel_q;
   logic                          busy;
   logic                          ack;
   logic [BASE_W-1:0]             addr_f;
   logic                          unused_addr;

   assign wr_ctrl     = '{size: cfg_size, len: cfg_len, dir: cfg_dir};
   assign addr_f      = bus_addr[MIRROR_BIT:MIN_LOG];
   assign unused_addr = ^{bus_addr[ADDR_W-1:MIRROR_BIT+1], bus_addr[MIN_LOG-1:0]};

   csel_cfg_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_idx     (cfg_idx),
      .wr_base    (cfg_base),
      .wr_ctrl    (wr_ctrl),
      .busy       (busy),
      .access_end (ack),
      .base_q     (base_q),
      .ctrl_q     (ctrl_q)
   );

   csel_match #(.NUM_CH(NUM_CH), .BASE_W(BASE_W)) u_match (
      .addr_f (addr_f),
      .rd     (bus_rd),
      .base_q (base_q),
      .ctrl_q (ctrl_q),
      .hit    (hit)
   );

   csel_seq #(.NUM_CH(NUM_CH)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb   (bus_strb),
      .hit    (hit),
      .ctrl_q (ctrl_q),
      .sel_q  (sel_q),
      .busy   (busy),
      .ack    (ack)
   );

   assign cs_n    = ~sel_q;
   assign bus_ack = ack;

   // R4: a select never asserts on a channel that is switched off
   p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_strb) |=> ((~cs_n & ~$past(hit)) == '0));

   // R6: acknowledge only while some select is low
   p_ack_with_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> (cs_n != '1));

endmodule

// File: tb/csel_bank_bench.sv
module csel_bank_bench;

   localparam int NUM_CH = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [3:0]        cfg_idx = '0;
   logic [8:0]        cfg_base = '0;
   logic [2:0]        cfg_size = '0;
   logic [3:0]        cfg_len = '0;
   logic [1:0]        cfg_dir = '0;
   logic [23:0]       bus_addr = '0;
   logic              bus_strb = 1'b0;
   logic              bus_rd = 1'b1;
   logic [NUM_CH-1:0] cs_n;
   logic              bus_ack;

   always #4 clk = ~clk;

   csel_bank u_csel_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_len(cfg_len),
      .cfg_dir(cfg_dir), .bus_addr(bus_addr), .bus_strb(bus_strb),
      .bus_rd(bus_rd), .cs_n(cs_n), .bus_ack(bus_ack)
   );

   int nchecks = 0;
   int nfail   = 0;

   int m_base [NUM_CH];
   int m_size [NUM_CH];
   int m_len  [NUM_CH];
   int m_dir  [NUM_CH];

   int mw_idx [2];
   int mw_base[2];
   int mw_size[2];
   int mw_len [2];
   int mw_dir [2];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int win_bytes(input int code);
      case (code)
         1: return 2048;
         2: return 8192;
         3: return 16384;
         4: return 65536;
         5: return 131072;
         6: return 262144;
         7: return 524288;
         default: return 0;
      endcase
   endfunction

   task automatic model_eval(input logic [23:0] a, input logic rd,
                             output logic [NUM_CH-1:0] eh, output int L);
      int av;
      av = int'(a) % (1 << 20);
      eh = '0;
      L  = 0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         int b;
         bit dok;
         b   = win_bytes(m_size[ch]);
         dok = rd ? m_dir[ch][0] : m_dir[ch][1];
         if (b != 0 && dok && (av / b) == ((m_base[ch] * 2048) / b)) begin
            if (eh == '0) L = (m_len[ch] < 2) ? 2 : m_len[ch] + 1;
            eh[ch] = 1'b1;
         end
      end
   endtask

   task automatic put_cfg(input int idx, input int base, input int size,
                          input int len, input int dir);
      cfg_idx  = 4'(idx);
      cfg_base = 9'(base);
      cfg_size = 3'(size);
      cfg_len  = 4'(len);
      cfg_dir  = 2'(dir);
   endtask

   task automatic cfg_write(input int idx, input int base, input int size,
                            input int len, input int dir);
      @(negedge clk);
      put_cfg(idx, base, size, len, dir);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      m_base[idx] = base; m_size[idx] = size; m_len[idx] = len; m_dir[idx] = dir;
   endtask

   task automatic do_access(input logic [23:0] a, input logic rd, input bit again,
                            input int nw, input string req);
      logic [NUM_CH-1:0] eh;
      int L;
      model_eval(a, rd, eh, L);
      @(negedge clk);
      bus_addr = a; bus_rd = rd; bus_strb = 1'b1;
      @(negedge clk);
      bus_strb = 1'b0;
      if (eh == '0) begin
         for (int i = 0; i < 3; i++) begin
            check(cs_n == '1, req, "select on miss", longint'(cs_n), 64'hfff);
            check(bus_ack == 1'b0, req, "ack on miss", longint'(bus_ack), 0);
            @(negedge clk);
         end
      end else begin
         for (int i = 1; i <= L; i++) begin
            check(cs_n == ~eh, req, "select pattern", longint'(cs_n), longint'(~eh));
            check(bus_ack == (i == L), req, "ack position", longint'(bus_ack),
                  longint'(i == L));
            bus_strb = again && (i == 1);
            if (i <= nw) begin
               put_cfg(mw_idx[i-1], mw_base[i-1], mw_size[i-1], mw_len[i-1], mw_dir[i-1]);
               cfg_we = 1'b1;
            end else begin
               cfg_we = 1'b0;
            end
            @(negedge clk);
         end
         bus_strb = 1'b0;
         cfg_we   = 1'b0;
         check(cs_n == '1, req, "release after ack", longint'(cs_n), 64'hfff);
         check(bus_ack == 1'b0, req, "ack single pulse", longint'(bus_ack), 0);
         if (nw > 0) begin
            int k;
            k = nw - 1;
            m_base[mw_idx[k]] = mw_base[k]; m_size[mw_idx[k]] = mw_size[k];
            m_len[mw_idx[k]]  = mw_len[k];  m_dir[mw_idx[k]]  = mw_dir[k];
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NUM_CH; i++) begin
         m_base[i] = 0; m_size[i] = 0; m_len[i] = 0; m_dir[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4: reset leaves all channels off
      check(cs_n == '1, "R1", "reset selects", longint'(cs_n), 64'hfff);
      check(bus_ack == 1'b0, "R1", "reset ack", longint'(bus_ack), 0);
      do_access(24'h000000, 1'b1, 1'b0, 0, "R4");
      do_access(24'h0A1234, 1'b0, 1'b0, 0, "R4");

      // R2 R3: every size code, window edges, mirrored top bits
      for (int code = 1; code <= 7; code++) begin
         int b, st;
         cfg_write(3, 'h155, code, 2, 3);
         b  = win_bytes(code);
         st = ('h155 * 2048) & ~(b - 1);
         do_access(24'(st), 1'b1, 1'b0, 0, "R2");
         do_access(24'(st + b - 1), 1'b0, 1'b0, 0, "R2");
         do_access(24'((st + b) % (1 << 20)), 1'b1, 1'b0, 0, "R2");
         do_access(24'((st + (1 << 20) - 1) % (1 << 20)), 1'b1, 1'b0, 0, "R2");
         do_access(24'(st + b / 2) | 24'hA00000, 1'b1, 1'b0, 0, "R3");
      end
      cfg_write(3, 0, 0, 0, 0);

      // R5 R6: every length code
      for (int lc = 0; lc < 16; lc++) begin
         cfg_write(5, 'h010, 1, lc, 3);
         do_access(24'h008005, 1'b1, 1'b0, 0, "R5");
      end

      // R4: direction mask
      cfg_write(5, 'h010, 1, 3, 1);
      do_access(24'h008100, 1'b1, 1'b0, 0, "R4");
      do_access(24'h008100, 1'b0, 1'b0, 0, "R4");
      cfg_write(5, 'h010, 1, 3, 2);
      do_access(24'h008100, 1'b1, 1'b0, 0, "R4");
      do_access(24'h008100, 1'b0, 1'b0, 0, "R4");
      cfg_write(5, 'h010, 1, 3, 0);
      do_access(24'h008100, 1'b1, 1'b0, 0, "R4");
      do_access(24'h008100, 1'b0, 1'b0, 0, "R4");

      // R7: overlapping windows, lowest channel sets length
      cfg_write(2, 'h020, 4, 4, 3);
      cfg_write(7, 'h020, 1, 9, 3);
      do_access(24'h010400, 1'b1, 1'b0, 0, "R7");
      do_access(24'h018000, 1'b0, 1'b0, 0, "R7");
      cfg_write(2, 'h020, 4, 4, 0);
      do_access(24'h010400, 1'b1, 1'b0, 0, "R7");

      // R8: strobe during an access, strobe with no hit
      do_access(24'h010400, 1'b1, 1'b1, 0, "R8");
      do_access(24'h0F0000, 1'b1, 1'b0, 0, "R8");

      // R9: two writes inside an access, only the later one lands
      mw_idx[0] = 7; mw_base[0] = 'h020; mw_size[0] = 0; mw_len[0] = 9; mw_dir[0] = 3;
      mw_idx[1] = 2; mw_base[1] = 'h020; mw_size[1] = 4; mw_len[1] = 6; mw_dir[1] = 3;
      do_access(24'h010400, 1'b1, 1'b0, 2, "R9");
      do_access(24'h010400, 1'b1, 1'b0, 0, "R9");

      // R9: a single write inside an access applies after it
      mw_idx[0] = 7; mw_base[0] = 'h020; mw_size[0] = 0; mw_len[0] = 9; mw_dir[0] = 3;
      do_access(24'h010400, 1'b0, 1'b0, 1, "R9");
      do_access(24'h010400, 1'b0, 1'b0, 0, "R9");

      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

endmodule